// File: doc/BRIEF.md
# Sample-Period Wall Clock with Interval Timer

This block keeps audio time. Each pulse on the slot strobe marks the end of one channel-service slot. A sample period is made of 2^CHAN_W slots, which is 64 at the default setting. A slot index counts through those slots. A sample-period count, placed directly above the slot index, advances each time the slot index wraps. Software reads both fields together as one wall-clock word.

A programmable interval timer counts whole sample periods. When a programmed number of periods has completed, it emits a single-cycle event that the interrupt controller latches. The rate register is 10 bits wide, and a rate of zero means 1024 periods. A new rate does not disturb the interval already running. The down-counter reloads from the rate only at terminal count, so any change settles within one old interval, which is never longer than 1024 periods.

All pins are plain control and status signals. The block has no data stream, so it needs no valid/ready handshake and applies no back-pressure.

Top module: `sample_timebase`

## Requirements
- R1: The slot index in wall_clock bits [CHAN_W-1:0] (bits 5:0 by default) resets to 0. It rises by one on each clock edge where slot_tick is high, and goes from 2^CHAN_W-1 (63) back to 0.
- R2: The period count in wall_clock bits [CHAN_W+SAMPLE_W-1:CHAN_W] (bits 25:6 by default) resets to 0. It rises by one on the edge where the slot index wraps, and rolls over silently modulo 2^SAMPLE_W.
- R3: On a clock edge where slot_tick is low, wall_clock keeps its value and the timer makes no progress.
- R4: After reset, tmr_event is low and rate_q is 0. The first interval lasts 1024 sample periods.
- R5: tmr_event is high for exactly one cycle. It is registered on the edge that completes the last period of an interval, which is the same edge on which the period count advances.
- R6: A rate value of 0 produces intervals of 1024 sample periods.
- R7: A write (rate_we high) updates rate_q on the next edge. The interval already running finishes under the old rate, and the new rate applies from the next terminal count.
- R8: Rate values 1 through 4 are accepted without error. A rate of 1 produces an event at the end of every sample period.
- R9: If a write falls on the same edge as a terminal count, the written value sets the length of the interval that starts on that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_tick | input | 1 | One channel-service slot has elapsed |
| rate_we | input | 1 | Write strobe for the timer rate |
| rate_wdata | input | RATE_W | New timer rate in sample periods (0 means 2^RATE_W) |
| rate_q | output | RATE_W | Programmed timer rate, for read-back |
| wall_clock | output | SAMPLE_W+CHAN_W | Period count above slot index |
| tmr_event | output | 1 | One-cycle pulse at timer terminal count |

## Verification
Every result appears one clock edge after the input that causes it. This applies to the slot index, the period count, rate_q, and tmr_event, which is registered on the edge that ends the last period of an interval. The bench applies inputs after a falling edge, updates its arithmetic model for the rising edge that follows, and compares every output at the next falling edge. No output is ever sampled at the edge it is due. Interval lengths are measured from the events the design actually produces, counted in sample periods, and are checked against the lengths the requirements predict.

// File: rtl/wclk_pkg.sv
package wclk_pkg;
  parameter int unsigned CHAN_W_DEF   = 6;
  parameter int unsigned SAMPLE_W_DEF = 20;
  parameter int unsigned RATE_W_DEF   = 10;
endpackage

// File: rtl/slot_sequencer.sv
module slot_sequencer #(
  parameter int unsigned CHAN_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slot_tick,
  output logic [CHAN_W-1:0] chan,
  output logic              period_end
);
  localparam logic [CHAN_W-1:0] LAST = {CHAN_W{1'b1}};

  // a period ends on the tick that leaves the last slot
  assign period_end = slot_tick && (chan == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)         chan <= '0;
    else if (slot_tick) chan <= chan + 1'b1;
  end
endmodule

// File: rtl/period_counter.sv
module period_counter #(
  parameter int unsigned SAMPLE_W = 20
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                period_end,
  output logic [SAMPLE_W-1:0] periods
);
  // silent wrap at the top of the range
  always_ff @(posedge clk) begin
    if (!rst_n)          periods <= '0;
    else if (period_end) periods <= periods + 1'b1;
  end
endmodule

// File: rtl/interval_timer.sv
module interval_timer #(
  parameter int unsigned RATE_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              period_end,
  input  logic              rate_we,
  input  logic [RATE_W-1:0] rate_wdata,
  output logic [RATE_W-1:0] rate_q,
  output logic              tmr_event
);
  localparam int unsigned CNT_W = RATE_W + 1;
  localparam logic [CNT_W-1:0] FULL = CNT_W'(1) << RATE_W;
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  logic [CNT_W-1:0]  remain;
  logic [RATE_W-1:0] eff_rate;
  logic [CNT_W-1:0]  load_val;

  // a write on the terminal edge is used straight away
  assign eff_rate = rate_we ? rate_wdata : rate_q;
  assign load_val = (eff_rate == '0) ? FULL : {1'b0, eff_rate};

  always_ff @(posedge clk) begin
    if (!rst_n)       rate_q <= '0;
    else if (rate_we) rate_q <= rate_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      remain    <= FULL;
      tmr_event <= 1'b0;
    end else if (period_end) begin
      if (remain == ONE) begin
        remain    <= load_val;
        tmr_event <= 1'b1;
      end else begin
        remain    <= remain - ONE;
        tmr_event <= 1'b0;
      end
    end else begin
      tmr_event <= 1'b0;
    end
  end
endmodule

// File: rtl/sample_timebase.sv
module sample_timebase #(
  parameter int unsigned CHAN_W   = wclk_pkg::CHAN_W_DEF,
  parameter int unsigned SAMPLE_W = wclk_pkg::SAMPLE_W_DEF,
  parameter int unsigned RATE_W   = wclk_pkg::RATE_W_DEF
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       slot_tick,
  input  logic                       rate_we,
  input  logic [RATE_W-1:0]          rate_wdata,
  output logic [RATE_W-1:0]          rate_q,
  output logic [SAMPLE_W+CHAN_W-1:0] wall_clock,
  output logic                       tmr_event
);
  logic [CHAN_W-1:0]   chan;
  logic [SAMPLE_W-1:0] periods;
  logic                period_end;

  slot_sequencer #(.CHAN_W(CHAN_W)) u_slots (
    .clk(clk), .rst_n(rst_n), .slot_tick(slot_tick),
    .chan(chan), .period_end(period_end)
  );

  period_counter #(.SAMPLE_W(SAMPLE_W)) u_periods (
    .clk(clk), .rst_n(rst_n), .period_end(period_end), .periods(periods)
  );

  interval_timer #(.RATE_W(RATE_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .period_end(period_end),
    .rate_we(rate_we), .rate_wdata(rate_wdata),
    .rate_q(rate_q), .tmr_event(tmr_event)
  );

  assign wall_clock = {periods, chan};
endmodule

// File: rtl/sample_timebase_chk.sv
module sample_timebase_chk #(
  parameter int unsigned CHAN_W   = 6,
  parameter int unsigned SAMPLE_W = 20,
  parameter int unsigned RATE_W   = 10
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       slot_tick,
  input logic                       rate_we,
  input logic [RATE_W-1:0]          rate_wdata,
  input logic [RATE_W-1:0]          rate_q,
  input logic [SAMPLE_W+CHAN_W-1:0] wall_clock,
  input logic                       tmr_event
);
  localparam logic [CHAN_W-1:0] LAST = {CHAN_W{1'b1}};

  logic past_ok;
  always_ff @(posedge clk) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  logic [CHAN_W-1:0]   ch;
  logic [SAMPLE_W-1:0] sp;
  assign ch = wall_clock[CHAN_W-1:0];
  assign sp = wall_clock[SAMPLE_W+CHAN_W-1:CHAN_W];

  p_slot_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(slot_tick) |-> ch == $past(ch) + 1'b1);

  p_period_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(slot_tick) && $past(ch) == LAST |-> sp == $past(sp) + 1'b1);

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && !$past(slot_tick) |-> $stable(wall_clock) && !tmr_event);

  p_single_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_event |=> !tmr_event);

  p_event_at_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_event |-> ch == '0);

  p_rate_readback_r7: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(rate_we) |-> rate_q == $past(rate_wdata));
endmodule

bind sample_timebase sample_timebase_chk #(
  .CHAN_W(CHAN_W), .SAMPLE_W(SAMPLE_W), .RATE_W(RATE_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .slot_tick(slot_tick), .rate_we(rate_we),
  .rate_wdata(rate_wdata), .rate_q(rate_q), .wall_clock(wall_clock),
  .tmr_event(tmr_event)
);

// File: tb/tb_sample_timebase.sv
`timescale 1ns/1ps
module tb_sample_timebase;
  localparam int CW = 6;
  localparam int SW = 8;
  localparam int RW = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic slot_tick = 1'b0;
  logic rate_we = 1'b0;
  logic [RW-1:0] rate_wdata = '0;
  logic [RW-1:0] rate_q;
  logic [SW+CW-1:0] wall_clock;
  logic tmr_event;

  always #5 clk = ~clk;

  sample_timebase #(.CHAN_W(CW), .SAMPLE_W(SW), .RATE_W(RW)) dut (
    .clk(clk), .rst_n(rst_n), .slot_tick(slot_tick), .rate_we(rate_we),
    .rate_wdata(rate_wdata), .rate_q(rate_q), .wall_clock(wall_clock),
    .tmr_event(tmr_event)
  );

  int n_chk = 0, n_bad = 0;
  // model state, from the requirements
  int m_chan = 0, m_samp = 0, m_rate = 0, m_remain = 1024, m_evt = 0;
  int periods = 0;
  // observed events
  int obs_cnt = 0, obs_last = 0;
  int obs_iv [0:31];
  bit done = 0;

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(bit t, bit w, int d);
    int pend;
    slot_tick = t; rate_we = w; rate_wdata = RW'(d);
    pend = w ? d : m_rate;
    if (w) m_rate = d;
    m_evt = 0;
    if (t) begin
      if (m_chan == 63) begin
        m_chan = 0;
        m_samp = (m_samp + 1) % 256;
        periods++;
        if (m_remain == 1) begin
          m_remain = (pend == 0) ? 1024 : pend;
          m_evt = 1;
        end else m_remain--;
      end else m_chan++;
    end
    @(negedge clk);
    check(t ? "R1" : "R3", int'(wall_clock[CW-1:0]), m_chan);
    check(t ? "R2" : "R3", int'(wall_clock[SW+CW-1:CW]), m_samp);
    check("R5", int'(tmr_event), m_evt);
    check("R7", int'(rate_q), m_rate);
    if (tmr_event) begin
      if (obs_cnt < 32) obs_iv[obs_cnt] = periods - obs_last;
      obs_cnt++;
      obs_last = periods;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R4: reset state
    check("R4", int'(wall_clock), 0);
    check("R4", int'(tmr_event), 0);
    check("R4", int'(rate_q), 0);
    // R3: idle slots hold everything
    repeat (20) cyc(0, 0, 0);
    while (periods < 100) cyc(1, 0, 0);
    cyc(1, 1, 3);                              // R7: mid-interval write
    while (obs_cnt < 4) cyc(1, 0, 0);
    repeat (64) cyc(1, 0, 0);
    cyc(1, 1, 1);                              // R8: rate 1
    while (obs_cnt < 8) cyc(1, 0, 0);
    while (m_chan != 63) cyc(1, 0, 0);
    cyc(1, 1, 2);                              // R9: write on terminal edge
    while (obs_cnt < 11) cyc(1, 0, 0);
    repeat (64) cyc(1, 0, 0);
    cyc(1, 1, 0);                              // R6: back to 1024
    while (obs_cnt < 13) cyc(1, 0, 0);
    repeat (5) cyc(1, 0, 0);
    check("R4", obs_iv[0], 1024);   // first interval after reset
    check("R6", obs_iv[0], 1024);
    check("R7", obs_iv[1], 3);      // new rate from next terminal count
    check("R7", obs_iv[3], 3);
    check("R7", obs_iv[4], 3);      // old rate finishes after write of 1
    check("R8", obs_iv[5], 1);
    check("R8", obs_iv[7], 1);
    check("R9", obs_iv[8], 1);
    check("R9", obs_iv[9], 2);      // written value used on coinciding edge
    check("R9", obs_iv[10], 2);
    check("R7", obs_iv[11], 2);
    check("R6", obs_iv[12], 1024);
    done = 1;
  end

  initial begin
    for (int i = 0; i < 190000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule